// File: doc/BRIEF.md
# Serial Audio Multi-Role Pin Controller

This block controls one pad of a serial audio port. Depending on a set of mode bits, the same pad can do one of several jobs. It can carry the receive frame sync, in either direction. It can carry a serial flag, as an output flag or as an input flag. It can drive the enable of an external transmit buffer. It can also be a general-purpose I/O bit, and in that case it is an input, an output or fully disconnected. The mode bits come from a control register outside the block. The block decides the pad's role and produces the pad output value and the output enable. It also returns the sampled pad level to whichever function owns the pad.

Flag values do not move between the register and the pad at once. The output flag copy and the captured input flag both change only on a transfer boundary. That boundary is the internal frame sync in normal operation, or the slot strobe in network operation. The raw pad level goes through a two-stage synchronizer before any internal logic uses it. All outputs are registered and reset to zero, which leaves the pad undriven.

Top module: `audio_pin_mux`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `pin_out`, `pin_oe`, `if1_status`, `gpio_rd` and `rx_fs` are all 0.
- R2: When `gpio_en`=1, the pad is a GPIO whatever the other mode bits are. The GPIO setting is chosen by `gpio_cfg`. With `gpio_cfg`=2'b10 the pad is an output: `pin_oe`=1 and `pin_out`=`gpio_wr`. With `gpio_cfg`=2'b01 the pad is an input: `pin_oe`=0. With 2'b00 or 2'b11 the pad is disconnected: `pin_oe`=0 and `gpio_rd`=0.
- R3: When `gpio_en`=0 and `sync_mode`=0, the pad is the receive frame sync. With `rfs_dir`=1 the block drives `fs_int` onto the pad with `pin_oe`=1. With `rfs_dir`=0 the pad is an input (`pin_oe`=0) and `rx_fs` follows the synchronized pad level.
- R4: When `gpio_en`=0, `sync_mode`=1, `bufen_sel`=1 and `rfs_dir`=1, the pad drives `tx_buf_en` with `pin_oe`=1.
- R5: When `gpio_en`=0, `sync_mode`=1, `bufen_sel`=1 and `rfs_dir`=0, the pad is tri-stated (`pin_oe`=0).
- R6: When `gpio_en`=0, `sync_mode`=1, `bufen_sel`=0 and `rfs_dir`=1, the pad is the output flag. `pin_oe`=1 and `pin_out` shows a held copy of `of1_bit`. That copy loads only on a transfer boundary.
- R7: When `gpio_en`=0, `sync_mode`=1, `bufen_sel`=0 and `rfs_dir`=0, the pad is the input flag. The synchronized pad level loads into `if1_status` only on a transfer boundary. In every other mode `if1_status` holds its value.
- R8: The transfer boundary is `fs_int` when `net_mode`=0 and `slot_strobe` when `net_mode`=1. The strobe that is not selected has no effect.
- R9: `gpio_rd` shows the pad level in GPIO input or output setting. A pad change appears on `gpio_rd` at the third rising edge after it, not earlier.
- R10: Whenever `pin_oe` is 0, `pin_out` is 0. `rx_fs` is 0 outside the frame-sync-input role. Port outputs follow a mode change one clock later.

Each row of the port table below states its width, direction and purpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_en | input | 1 | Pad is general-purpose I/O; overrides all serial roles |
| gpio_cfg | input | 2 | GPIO setting: 01 input, 10 output, 00/11 disconnected |
| gpio_wr | input | 1 | GPIO output value |
| sync_mode | input | 1 | Synchronous (shared-clocking) serial operation |
| bufen_sel | input | 1 | In synchronous operation, select buffer-enable role over flag role |
| rfs_dir | input | 1 | Direction bit: 1 drive, 0 receive |
| net_mode | input | 1 | Network operation: transfer boundary is the slot strobe |
| fs_int | input | 1 | Internal frame sync |
| slot_strobe | input | 1 | Internal slot boundary strobe |
| of1_bit | input | 1 | Output flag register bit |
| tx_buf_en | input | 1 | Internal transmit buffer enable level |
| pin_in | input | 1 | Raw pad input level |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output enable |
| if1_status | output | 1 | Captured input flag |
| gpio_rd | output | 1 | GPIO read data |
| rx_fs | output | 1 | Synchronized external frame sync for the receivers |

## Verification
Two events can fall on the same clock edge. One is a transfer boundary. The other is a change of the value that the boundary moves, which is either `of1_bit` or the pad level. The bench also pulses `fs_int` and `slot_strobe` together in network operation. In that case only the slot strobe may move the flag, and an `fs_int` pulse on its own must move nothing. In each case the bench samples the flag a few cycles after the pulse and compares it with the value that was present at the single enabled edge. A near-exhaustive sweep over all mode-bit combinations checks the role priority.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [3:0] {
    ROLE_GPIO_OFF,
    ROLE_GPIO_IN,
    ROLE_GPIO_OUT,
    ROLE_FS_IN,
    ROLE_FS_OUT,
    ROLE_FLAG_IN,
    ROLE_FLAG_OUT,
    ROLE_BUF_EN,
    ROLE_HIZ
  } role_t;

  localparam logic [1:0] GPIO_CFG_IN  = 2'b01;
  localparam logic [1:0] GPIO_CFG_OUT = 2'b10;
endpackage

// File: rtl/apm_sync.sv
module apm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/apm_role_dec.sv
module apm_role_dec
  import apm_pkg::*;
(
  input  logic       gpio_en,
  input  logic [1:0] gpio_cfg,
  input  logic       sync_mode,
  input  logic       bufen_sel,
  input  logic       rfs_dir,
  output role_t      role
);
  always_comb begin
    if (gpio_en) begin
      if (gpio_cfg == GPIO_CFG_OUT)     role = ROLE_GPIO_OUT;
      else if (gpio_cfg == GPIO_CFG_IN) role = ROLE_GPIO_IN;
      else                              role = ROLE_GPIO_OFF;
    end else if (!sync_mode) begin
      role = rfs_dir ? ROLE_FS_OUT : ROLE_FS_IN;
    end else if (!bufen_sel) begin
      role = rfs_dir ? ROLE_FLAG_OUT : ROLE_FLAG_IN;
    end else begin
      role = rfs_dir ? ROLE_BUF_EN : ROLE_HIZ;
    end
  end
endmodule

// File: rtl/apm_flag_unit.sv
module apm_flag_unit
  import apm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  role_t role,
  input  logic  net_mode,
  input  logic  fs_int,
  input  logic  slot_strobe,
  input  logic  of1_bit,
  input  logic  pin_s,
  output logic  of1_q,
  output logic  if1_q
);
  logic boundary;
  logic ld_out;
  logic ld_in;

  assign boundary = net_mode ? slot_strobe : fs_int;
  assign ld_out   = boundary && (role == ROLE_FLAG_OUT);
  assign ld_in    = boundary && (role == ROLE_FLAG_IN);

  always_ff @(posedge clk) begin
    if (rst) begin
      of1_q <= 1'b0;
      if1_q <= 1'b0;
    end else begin
      if (ld_out) of1_q <= of1_bit;
      if (ld_in)  if1_q <= pin_s;
    end
  end

  AST_OF1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !((role == ROLE_FLAG_OUT) && (net_mode ? slot_strobe : fs_int)) |=> $stable(of1_q)); // R6
  AST_IF1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (role != ROLE_FLAG_IN) |=> $stable(if1_q)); // R7
  AST_STROBE_SELECT: assert property (@(posedge clk) disable iff (rst)
    ((role == ROLE_FLAG_IN) && net_mode && !slot_strobe) |=> $stable(if1_q)); // R8
endmodule

// File: rtl/audio_pin_mux.sv
module audio_pin_mux
  import apm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gpio_en,
  input  logic [1:0] gpio_cfg,
  input  logic       gpio_wr,
  input  logic       sync_mode,
  input  logic       bufen_sel,
  input  logic       rfs_dir,
  input  logic       net_mode,
  input  logic       fs_int,
  input  logic       slot_strobe,
  input  logic       of1_bit,
  input  logic       tx_buf_en,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       if1_status,
  output logic       gpio_rd,
  output logic       rx_fs
);
  role_t role;
  logic  pin_s;
  logic  of1_q;
  logic  nxt_out, nxt_oe, nxt_rd, nxt_fs;

  apm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  apm_role_dec u_dec (
    .gpio_en(gpio_en), .gpio_cfg(gpio_cfg), .sync_mode(sync_mode),
    .bufen_sel(bufen_sel), .rfs_dir(rfs_dir), .role(role)
  );

  apm_flag_unit u_flag (
    .clk(clk), .rst(rst), .role(role), .net_mode(net_mode),
    .fs_int(fs_int), .slot_strobe(slot_strobe), .of1_bit(of1_bit),
    .pin_s(pin_s), .of1_q(of1_q), .if1_q(if1_status)
  );

  always_comb begin
    nxt_out = 1'b0;
    nxt_oe  = 1'b0;
    unique case (role)
      ROLE_GPIO_OUT: begin nxt_oe = 1'b1; nxt_out = gpio_wr;   end
      ROLE_FS_OUT:   begin nxt_oe = 1'b1; nxt_out = fs_int;    end
      ROLE_FLAG_OUT: begin nxt_oe = 1'b1; nxt_out = of1_q;     end
      ROLE_BUF_EN:   begin nxt_oe = 1'b1; nxt_out = tx_buf_en; end
      default:       begin nxt_oe = 1'b0; nxt_out = 1'b0;      end
    endcase
    nxt_rd = ((role == ROLE_GPIO_IN) || (role == ROLE_GPIO_OUT)) ? pin_s : 1'b0;
    nxt_fs = (role == ROLE_FS_IN) ? pin_s : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
      gpio_rd <= 1'b0;
      rx_fs   <= 1'b0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
      gpio_rd <= nxt_rd;
      rx_fs   <= nxt_fs;
    end
  end

  AST_HIZ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!gpio_en && sync_mode && bufen_sel && !rfs_dir) |=> !pin_oe); // R5
  AST_GPIO_FIRST: assert property (@(posedge clk) disable iff (rst)
    (gpio_en && gpio_cfg == GPIO_CFG_OUT) |=> (pin_oe && pin_out == $past(gpio_wr))); // R2
  AST_GPIO_OFF_READ: assert property (@(posedge clk) disable iff (rst)
    (gpio_en && gpio_cfg != GPIO_CFG_IN && gpio_cfg != GPIO_CFG_OUT) |=> (!gpio_rd && !pin_oe)); // R2
  AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out); // R10
  AST_BUFEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!gpio_en && sync_mode && bufen_sel && rfs_dir) |=> (pin_oe && pin_out == $past(tx_buf_en))); // R4
endmodule

// File: tb/test_audio_pin_mux.sv
`timescale 1ns/1ps
module test_audio_pin_mux;
  logic clk = 1'b0;
  logic rst;
  logic gpio_en, gpio_wr, sync_mode, bufen_sel, rfs_dir, net_mode;
  logic fs_int, slot_strobe, of1_bit, tx_buf_en, pin_in;
  logic [1:0] gpio_cfg;
  logic pin_out, pin_oe, if1_status, gpio_rd, rx_fs;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  audio_pin_mux i_audio_pin_mux (
    .clk(clk), .rst(rst), .gpio_en(gpio_en), .gpio_cfg(gpio_cfg),
    .gpio_wr(gpio_wr), .sync_mode(sync_mode), .bufen_sel(bufen_sel),
    .rfs_dir(rfs_dir), .net_mode(net_mode), .fs_int(fs_int),
    .slot_strobe(slot_strobe), .of1_bit(of1_bit), .tx_buf_en(tx_buf_en),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .if1_status(if1_status), .gpio_rd(gpio_rd), .rx_fs(rx_fs)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic g, input logic s, input logic b, input logic d);
    gpio_en = g; sync_mode = s; bufen_sel = b; rfs_dir = d;
  endtask

  task automatic pulse(input logic f, input logic sl);
    fs_int = f; slot_strobe = sl;
    cyc(1);
    fs_int = 1'b0; slot_strobe = 1'b0;
    cyc(3);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_mode(0, 0, 0, 0);
    gpio_cfg = 2'b00; gpio_wr = 0; net_mode = 0; fs_int = 0; slot_strobe = 0;
    of1_bit = 0; tx_buf_en = 0; pin_in = 0;
    cyc(3);
    // R1 reset state
    chk("R1", "pin_out", pin_out, 1'b0);
    chk("R1", "pin_oe", pin_oe, 1'b0);
    chk("R1", "if1_status", if1_status, 1'b0);
    chk("R1", "gpio_rd", gpio_rd, 1'b0);
    chk("R1", "rx_fs", rx_fs, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "pin_oe after release", pin_oe, 1'b0);

    // Sweep of mode bits, GPIO setting and data level (R2 R3 R4 R5 R10)
    for (int m = 0; m < 128; m++) begin
      logic g, s, b, d, v, e_oe, e_out, e_rd, e_fs, flag_out;
      logic [1:0] c;
      g = m[6]; s = m[5]; b = m[4]; d = m[3]; c = m[2:1]; v = m[0];
      set_mode(g, s, b, d);
      gpio_cfg = c; gpio_wr = v; fs_int = v; tx_buf_en = v; pin_in = v;
      of1_bit = 1'b0; net_mode = 1'b0;
      flag_out = !g && s && !b && d;
      if (g) begin
        e_oe  = (c == 2'b10);
        e_out = (c == 2'b10) ? v : 1'b0;
        e_rd  = (c == 2'b01 || c == 2'b10) ? v : 1'b0;
        e_fs  = 1'b0;
      end else if (!s) begin
        e_oe  = d;
        e_out = d ? v : 1'b0;
        e_rd  = 1'b0;
        e_fs  = d ? 1'b0 : v;
      end else begin
        e_oe  = d;
        e_out = (b && d) ? v : 1'b0;
        e_rd  = 1'b0;
        e_fs  = 1'b0;
      end
      cyc(4);
      chk(g ? "R2" : (!s ? "R3" : (b ? (d ? "R4" : "R5") : "R6")), "pin_oe", pin_oe, e_oe);
      if (!flag_out) chk(g ? "R2" : "R10", "pin_out", pin_out, e_out);
      chk("R2", "gpio_rd", gpio_rd, e_rd);
      chk("R3", "rx_fs", rx_fs, e_fs);
    end
    fs_int = 1'b0; tx_buf_en = 1'b0; gpio_wr = 1'b0;

    // R6 output flag: held copy, loads only at boundary
    set_mode(0, 1, 0, 1);
    net_mode = 0; of1_bit = 1'b1;
    cyc(4);
    chk("R6", "flag out before boundary", pin_out, 1'b0);
    of1_bit = 1'b1;
    pulse(1, 0);
    chk("R6", "flag out after frame sync", pin_out, 1'b1);
    of1_bit = 1'b0;
    cyc(3);
    chk("R6", "flag out holds without boundary", pin_out, 1'b1);
    net_mode = 1'b1;
    pulse(1, 0);
    chk("R8", "frame sync ignored in network op", pin_out, 1'b1);
    pulse(0, 1);
    chk("R8", "slot strobe loads flag", pin_out, 1'b0);
    chk("R6", "flag out enable", pin_oe, 1'b1);

    // R7 input flag
    set_mode(0, 1, 0, 0);
    net_mode = 0; pin_in = 1'b0;
    cyc(4);
    pulse(1, 0);
    chk("R7", "if1 cleared", if1_status, 1'b0);
    chk("R7", "flag in undriven", pin_oe, 1'b0);
    pin_in = 1'b1;
    cyc(5);
    chk("R7", "if1 holds without boundary", if1_status, 1'b0);
    pulse(0, 1);
    chk("R8", "slot ignored in normal op", if1_status, 1'b0);
    pulse(1, 0);
    chk("R7", "if1 captured at frame sync", if1_status, 1'b1);
    net_mode = 1'b1; pin_in = 1'b0;
    cyc(4);
    pulse(1, 0);
    chk("R8", "frame sync ignored in network op", if1_status, 1'b1);
    pulse(0, 1);
    chk("R7", "if1 captured at slot", if1_status, 1'b0);
    pin_in = 1'b1;
    cyc(4);
    pulse(1, 1);
    chk("R8", "coincident strobes capture once", if1_status, 1'b1);
    // R7 hold outside mode
    pin_in = 1'b0;
    set_mode(1, 1, 0, 0); gpio_cfg = 2'b01;
    cyc(4);
    pulse(1, 1);
    chk("R7", "if1 holds in GPIO mode", if1_status, 1'b1);

    // R9 synchronizer latency
    pin_in = 1'b0;
    cyc(5);
    pin_in = 1'b1;
    cyc(2);
    chk("R9", "gpio_rd before third edge", gpio_rd, 1'b0);
    cyc(1);
    chk("R9", "gpio_rd at third edge", gpio_rd, 1'b1);

    // R10 one-cycle mode follow and quiet when undriven
    set_mode(1, 0, 0, 0); gpio_cfg = 2'b10; gpio_wr = 1'b1;
    cyc(1);
    chk("R10", "oe one cycle after mode", pin_oe, 1'b1);
    gpio_cfg = 2'b11;
    cyc(1);
    chk("R10", "pin_out quiet when undriven", pin_out, 1'b0);
    chk("R2", "disconnected read", gpio_rd, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule